// File: doc/BRIEF.md
# Stack push/pop execution unit

This unit carries out the one-byte stack opcodes of a 32-bit processor core against its own file of eight 32-bit general registers. A push opcode (0x50 to 0x57) copies a register onto the stack, and a pop opcode (0x58 to 0x5F) moves the top stack word into a register. Register 4 is the stack pointer (ESP). The stack lives in a byte-wide synchronous memory that sits outside the unit. Each operation moves its 32-bit word one byte per cycle, in little-endian order. The unit reports its progress with a busy level and a one-cycle done pulse.

The surrounding pipeline uses the unit in four steps:
- It presets registers through a load port.
- It presents one opcode while the unit is idle.
- It waits for the done pulse.
- It reads results through a combinational read port.

An opcode outside the stack range raises a one-cycle error pulse and changes nothing. The stack pointer needs no particular alignment. Address arithmetic wraps modulo 2^32.

Top module: `stk_pushpop_unit`

## Requirements
- R1: Register numbers are EAX=0, ECX=1, EDX=2, EBX=3, ESP=4, EBP=5, ESI=6, EDI=7. Opcode 0x50+n pushes register n, where n is op bits [2:0].
- R2: A push sets ESP to ESP-4 (mod 2^32) and stores the pushed value at the new ESP. Pushing ESP (0x54) stores the value ESP held before the decrement.
- R3: Opcode 0x58+n pops into register n. The value popped is the little-endian word at ESP: the byte at ESP is bits [7:0] and the byte at ESP+3 is bits [31:24]. ESP then becomes ESP+4 (mod 2^32).
- R4: Popping into ESP (0x5C) leaves ESP equal to the popped value. The increment is overridden by the register write.
- R5: The unit accesses memory one byte per cycle, lowest address first, at consecutive addresses that wrap at 2^32, with no alignment requirement. A push writes bits [8k+7:8k] to address ESP_new+k.
- R6: Timing is counted from the accepting clock edge.
  - busy_o goes high in the cycle after that edge and stays high through the done pulse.
  - done_o is a one-cycle pulse, in cycle 5 for a push and cycle 6 for a pop.
  - Registers show their new values in the cycle after the done pulse.
- R7: An opcode presented while busy_o is high is ignored. It raises no error and changes no register or memory.
- R8: An opcode outside 0x50..0x5F presented while idle gives a one-cycle err_o pulse in the next cycle. It changes no register and does not set busy_o.
- R9: After reset, all registers read zero and busy_o, done_o, err_o and mem_req_o are low.
- R10: rf_we_i loads rf_wdata_i into register rf_waddr_i only when the unit is idle and op_valid_i is low; otherwise the load is ignored. rf_rdata_o shows register rf_raddr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Opcode present |
| op_i | input | 8 | Opcode byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Unsupported opcode pulse |
| rf_we_i | input | 1 | Register load enable |
| rf_waddr_i | input | 3 | Register load index |
| rf_wdata_i | input | 32 | Register load value |
| rf_raddr_i | input | 3 | Register read index |
| rf_rdata_o | output | 32 | Register read value |
| mem_req_o | output | 1 | Memory byte access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after a read request |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and eight registers, with register 4 as the stack pointer. The bench's byte memory is 4 KiB and uses only the low 12 address bits. Because 2^32 is a multiple of that size, a stack pointer placed near zero exercises the full-width wrap: a push from ESP 0x2 writes bytes at 0xFFFFFFFE through 0x1. A small memory also makes random pushes and pops land on previously written locations often, so stale-byte and ordering errors show up.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [4:0] PUSH_BASE = 5'b01010; // 0x50..0x57
  localparam logic [4:0] POP_BASE  = 5'b01011; // 0x58..0x5F

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RD,
    S_CAP,
    S_FIN
  } seq_state_e;

  typedef struct packed {
    logic       legal;
    logic       is_pop;
    logic [2:0] idx;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] op);
    op_dec_t d;
    d.idx    = op[2:0];
    d.is_pop = (op[7:3] == POP_BASE);
    d.legal  = (op[7:3] == PUSH_BASE) || (op[7:3] == POP_BASE);
    return d;
  endfunction
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [7:0]       op_i,
  output logic             legal_o,
  output logic             is_pop_o,
  output logic [IDX_W-1:0] idx_o
);
  op_dec_t dec;

  always_comb begin
    dec      = decode_op(op_i);
    legal_o  = dec.legal;
    is_pop_o = dec.is_pop;
    idx_o    = IDX_W'(dec.idx);
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // port priority: dst > sp > ext
  input  logic              ext_we_i,
  input  logic [IDX_W-1:0]  ext_idx_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_data_i,
  input  logic              dst_we_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] dst_data_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  output logic [DATA_W-1:0] src_data_o,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [DATA_W-1:0] sp_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_dst, hit_sp, hit_ext;
    assign hit_dst = dst_we_i && (dst_idx_i == IDX_W'(g));
    assign hit_sp  = sp_we_i && (g == SP_IDX);
    assign hit_ext = ext_we_i && (ext_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_q[g] <= '0;
      else if (hit_dst) regs_q[g] <= dst_data_i;
      else if (hit_sp)  regs_q[g] <= sp_data_i;
      else if (hit_ext) regs_q[g] <= ext_data_i;
    end
  end

  assign src_data_o = regs_q[src_idx_i];
  assign dbg_data_o = regs_q[dbg_idx_i];
  assign sp_o       = regs_q[SP_IDX];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int NBYTE = DATA_W / 8,
  localparam int CNT_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              legal_i,
  input  logic              is_pop_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic              idle_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sp_we_o,
  output logic [DATA_W-1:0] sp_data_o,
  output logic              dst_we_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTE - 1);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(NBYTE);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              pop_q, pop_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              err_q, err_d;
  logic              accept;

  assign accept = (state_q == S_IDLE) && op_valid_i && legal_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    base_d    = base_q;
    word_d    = word_q;
    pop_d     = pop_q;
    idx_d     = idx_q;
    err_d     = 1'b0;
    sp_we_o   = 1'b0;
    sp_data_o = '0;
    dst_we_o  = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (op_valid_i && !legal_i) err_d = 1'b1;
        if (accept) begin
          pop_d = is_pop_i;
          idx_d = idx_i;
          cnt_d = '0;
          if (is_pop_i) begin
            base_d  = sp_i;
            state_d = S_RD;
          end else begin
            // source read before decrement: push of SP stores old value
            word_d    = src_data_i;
            base_d    = sp_i - STEP;
            sp_we_o   = 1'b1;
            sp_data_o = sp_i - STEP;
            state_d   = S_WR;
          end
        end
      end
      S_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = S_FIN;
      end
      S_RD: begin
        mem_req_o = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q != '0) word_d = {mem_rdata_i, word_q[DATA_W-1:8]};
        if (cnt_q == LAST) state_d = S_CAP;
      end
      S_CAP: begin
        word_d  = {mem_rdata_i, word_q[DATA_W-1:8]};
        state_d = S_FIN;
      end
      S_FIN: begin
        if (pop_q) begin
          sp_we_o   = 1'b1;
          sp_data_o = base_q + STEP;
          dst_we_o  = 1'b1;
        end
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      word_q  <= '0;
      pop_q   <= 1'b0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      word_q  <= word_d;
      pop_q   <= pop_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign idle_o      = (state_q == S_IDLE);
  assign busy_o      = !idle_o;
  assign done_o      = (state_q == S_FIN);
  assign err_o       = err_q;
  assign dst_idx_o   = idx_q;
  assign dst_data_o  = word_q;
  assign mem_addr_o  = base_q + DATA_W'(cnt_q);
  assign mem_wdata_o = word_q[8*cnt_q +: 8];
endmodule

// File: rtl/stk_pushpop_unit.sv
module stk_pushpop_unit #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic              rf_we_i,
  input  logic [IDX_W-1:0]  rf_waddr_i,
  input  logic [DATA_W-1:0] rf_wdata_i,
  input  logic [IDX_W-1:0]  rf_raddr_i,
  output logic [DATA_W-1:0] rf_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic              legal, is_pop;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] src_data, sp;
  logic              idle, ext_we;
  logic              sp_we, dst_we;
  logic [DATA_W-1:0] sp_data, dst_data;
  logic [IDX_W-1:0]  dst_idx;

  stk_decode #(.IDX_W(IDX_W)) u_dec (
    .op_i     (op_i),
    .legal_o  (legal),
    .is_pop_o (is_pop),
    .idx_o    (idx)
  );

  assign ext_we = rf_we_i && idle && !op_valid_i;

  stk_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SP_IDX(SP_IDX)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_we_i   (ext_we),
    .ext_idx_i  (rf_waddr_i),
    .ext_data_i (rf_wdata_i),
    .sp_we_i    (sp_we),
    .sp_data_i  (sp_data),
    .dst_we_i   (dst_we),
    .dst_idx_i  (dst_idx),
    .dst_data_i (dst_data),
    .src_idx_i  (idx),
    .src_data_o (src_data),
    .dbg_idx_i  (rf_raddr_i),
    .dbg_data_o (rf_rdata_o),
    .sp_o       (sp)
  );

  stk_seq #(.DATA_W(DATA_W), .NREG(NREG)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .legal_i     (legal),
    .is_pop_i    (is_pop),
    .idx_i       (idx),
    .src_data_i  (src_data),
    .sp_i        (sp),
    .idle_o      (idle),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .sp_we_o     (sp_we),
    .sp_data_o   (sp_data),
    .dst_we_o    (dst_we),
    .dst_idx_o   (dst_idx),
    .dst_data_o  (dst_data),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: rtl/stk_pushpop_chk.sv
module stk_pushpop_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mem_req_o,
  input logic [DATA_W-1:0] mem_addr_o
);
  assert_done_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_mem_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + DATA_W'(1)));

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
endmodule

bind stk_pushpop_unit stk_pushpop_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/stk_pushpop_unit_tb_top.sv
`timescale 1ns/1ps
module stk_pushpop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_in = '0;
  logic        busy, done, err;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic [2:0]  rf_raddr = '0;
  logic [31:0] rf_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  ram [4096];
  logic [31:0] ref_reg [8];
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  stk_pushpop_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op_in),
    .busy_o(busy), .done_o(done), .err_o(err),
    .rf_we_i(rf_we), .rf_waddr_i(rf_waddr), .rf_wdata_i(rf_wdata),
    .rf_raddr_i(rf_raddr), .rf_rdata_o(rf_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) ram[mem_addr[11:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[11:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ram_word(input logic [31:0] a);
    return {ram[(a + 32'd3) & 32'hFFF], ram[(a + 32'd2) & 32'hFFF],
            ram[(a + 32'd1) & 32'hFFF], ram[a & 32'hFFF]};
  endfunction

  task automatic get_reg(input int i, output logic [31:0] v);
    rf_raddr = 3'(i);
    #0.1;
    v = rf_rdata;
  endtask

  task automatic cmp_regs(input string req);
    logic [31:0] v;
    int bad = -1;
    for (int i = 0; i < 8; i++) begin
      get_reg(i, v);
      if (v !== ref_reg[i] && bad < 0) bad = i;
    end
    if (bad >= 0) begin
      get_reg(bad, v);
      chk(1'b0, req, $sformatf("register %0d", bad), v, ref_reg[bad]);
    end else chk(1'b1, req, "registers", 0, 0);
  endtask

  task automatic load_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 3'(i); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    ref_reg[i] = v;
  endtask

  // Issue a stack opcode, check timing, update and compare the model.
  task automatic run_op(input logic [7:0] op, input bit disturb);
    int n = 0;
    int errs = 0;
    int r = int'(op[2:0]);
    bit is_pop = op[3];
    logic [31:0] v, sp_new;
    if (is_pop) begin
      v = ram_word(ref_reg[4]);
      sp_new = ref_reg[4] + 32'd4;
    end else begin
      v = ref_reg[r];
      sp_new = ref_reg[4] - 32'd4;
    end
    @(negedge clk);
    op_valid = 1'b1; op_in = op;
    do begin
      @(negedge clk);
      op_valid = 1'b0; rf_we = 1'b0;
      n++;
      if (n == 1) chk(busy === 1'b1, "R6", "busy after accept", 32'(busy), 1);
      if (err) errs++;
      if (disturb && n == 2) begin
        op_valid = 1'b1; op_in = 8'($urandom);
        rf_we = 1'b1; rf_waddr = 3'($urandom); rf_wdata = $urandom;
      end
    end while (!done && n < 20);
    chk(n == (is_pop ? 6 : 5), "R6", "cycles to done", n, is_pop ? 6 : 5);
    if (disturb) chk(errs == 0, "R7", "no error while busy", errs, 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R6", "idle after done", {busy, done}, 0);
    ref_reg[4] = sp_new;
    if (is_pop) ref_reg[r] = v;
    if (!is_pop)
      chk(ram_word(sp_new) === v, "R5", "pushed bytes", ram_word(sp_new), v);
    cmp_regs(is_pop ? (r == 4 ? "R4" : "R3") : (r == 4 ? "R2" : "R1"));
  endtask

  task automatic bad_op(input logic [7:0] op);
    logic [31:0] v;
    @(negedge clk);
    op_valid = 1'b1; op_in = op;
    @(negedge clk);
    op_valid = 1'b0;
    chk(err === 1'b1 && busy === 1'b0, "R8", "error pulse", {busy, err}, 1);
    @(negedge clk);
    chk(err === 1'b0, "R8", "error single cycle", 32'(err), 0);
    cmp_regs("R8");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 4096; i++) ram[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) ref_reg[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && mem_req === 0, "R9", "reset outputs",
        {busy, done, err, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_regs("R9");

    // R10: loads and readback
    for (int i = 0; i < 8; i++) load_reg(i, 32'h1111_0000 + 32'(i));
    cmp_regs("R10");

    // R1/R2: push EBX at ESP 0x64
    load_reg(3, 32'h0000_000A);
    load_reg(4, 32'h64);
    run_op(8'h53, 1'b0);
    chk(ram[12'h060] === 8'h0A && ram[12'h061] === 8'h00, "R5", "low byte first",
        {ram[12'h061], ram[12'h060]}, 32'h000A);

    // R3: pop 0A 00 00 00 at 0x2000
    load_reg(4, 32'h2000);
    ram[0] = 8'h0A; ram[1] = 8'h00; ram[2] = 8'h00; ram[3] = 8'h00;
    run_op(8'h5B, 1'b0);
    get_reg(3, v);
    chk(v === 32'h0000_000A, "R3", "little-endian pop", v, 32'hA);

    // R2: push ESP stores old value
    load_reg(4, 32'h0000_0300);
    run_op(8'h54, 1'b0);
    chk(ram_word(32'h2FC) === 32'h300, "R2", "push ESP old value", ram_word(32'h2FC), 32'h300);

    // R4: pop into ESP
    load_reg(4, 32'h0000_0400);
    ram[12'h400] = 8'h78; ram[12'h401] = 8'h56; ram[12'h402] = 8'h34; ram[12'h403] = 8'h12;
    run_op(8'h5C, 1'b0);
    get_reg(4, v);
    chk(v === 32'h1234_5678, "R4", "ESP after pop into ESP", v, 32'h12345678);

    // R5: misaligned and wrap-around
    load_reg(4, 32'h0000_0103);
    run_op(8'h50, 1'b0);
    run_op(8'h5E, 1'b0);
    load_reg(4, 32'h0000_0002);
    run_op(8'h57, 1'b0);
    get_reg(4, v);
    chk(v === 32'hFFFF_FFFE, "R5", "SP wrap", v, 32'hFFFFFFFE);
    run_op(8'h59, 1'b0);

    // R8: out-of-range opcodes
    bad_op(8'h4F);
    bad_op(8'h60);
    bad_op(8'h00);

    // R7: disturbance while busy
    run_op(8'h52, 1'b1);
    run_op(8'h5D, 1'b1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int sel = int'($urandom % 20);
      if (sel == 0) load_reg(int'($urandom % 8), $urandom);
      else if (sel == 1) bad_op(8'h60 + 8'($urandom % 8'h90));
      else run_op(8'h50 + 8'($urandom % 16), sel < 4);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule